// File: doc/BRIEF.md
# ADC Software Trigger Controller

This block is the digital front of a shared analog-to-digital converter. Software steers it through one 32-bit control word on a plain write/read bus. The block derives a control-clock tick from one of four source clock enables. It turns self-clearing command bits into single-cycle start pulses, drives a continuous software trigger level, and passes external hardware trigger requests through. It also issues the sample/hold command toward the analog front end and raises an interrupt when the converter reports that its settings may be updated. A suspend bit blocks every trigger path without touching the converter enable.

A small state machine owns the conversion-request bit. It has five states. IDLE waits for software to write 1 to the request bit and then moves to ARMED. ARMED waits for a control tick while suspend is clear. It then goes to FIRE if the latched input code is valid, or to DROP if the code is reserved. FIRE emits the start pulse for one cycle and DROP emits nothing. Both move to HOLD unconditionally. HOLD returns to IDLE on the next control tick, and the request bit reads 0 from then on. The request bit reads 1 in every state except IDLE.

Top module: `adc_swtrig_ctrl`

## Requirements
- R1: After reset the control word reads 0. `conv_start`, `glob_pulse`, `glob_lvl`, `hw_trig_out`, `upd_irq` and `samp_cmd` are 0, and `adc_en` is 0.
- R2: The control word layout is as follows. Input code [5:0], conversion request 6, global pulse trigger 7, global level trigger 8, manual sample 9, suspend 10, interrupt enable 11, update-ready status 12 (read-only), converter enable 13, clock source [15:14], tick divider [21:16]. Bits [31:22] read 0. Bits 5:0 and 8 to 21 except 12 read back as written.
- R3: With source code s and divider value d, `ctl_tick` pulses once per d+1 asserted cycles of `src_en[s]`.
- R4: Writing 1 to bit 7 fires once. On the first control tick after the write, `glob_pulse` equals `sel_pulse` for exactly one clock, and bit 7 reads 0 from that tick on.
- R5: While bit 8 is 1 and suspend is 0, `glob_lvl` equals `sel_lvl`. Otherwise `glob_lvl` is 0.
- R6: Writing 1 to bit 6 gives a one-clock `conv_start` one cycle after the first control tick that follows the write. `conv_chan` then carries the input code. Bit 6 keeps reading 1 until the next control tick after the pulse. Writing 0 to bit 6 has no effect.
- R7: A request whose input code is 12 or above produces no `conv_start`. Its bit 6 is still cleared, with the same timing as in R6.
- R8: While suspend is 1, no `conv_start` and no `glob_pulse` is issued, and `glob_lvl` and `hw_trig_out` are 0. A pending request stays pending and fires after suspend clears. `adc_en` is unaffected.
- R9: While bit 9 is 1, `samp_cmd` is 1 whatever `auto_samp` is. Otherwise `samp_cmd` follows `auto_samp`.
- R10: `upd_set` sets status bit 12 and `upd_clr` clears it. When the bit goes from 0 to 1 with bit 11 set, `upd_irq` pulses for one clock together with the bit's rise.
- R11: While suspend is 0, `hw_trig_out` equals `hw_trig_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| src_en | input | 4 | Clock-enable strobes of the four candidate source clocks |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| sel_pulse | input | N_TRIG | Inputs that chose the global pulse trigger |
| sel_lvl | input | N_TRIG | Inputs that chose the global level trigger |
| hw_trig_in | input | N_TRIG | External hardware trigger requests |
| auto_samp | input | 1 | Sample request from the automatic sample timer |
| upd_set | input | 1 | Converter reports that settings may be updated |
| upd_clr | input | 1 | Converter withdraws the update-ready report |
| ctl_tick | output | 1 | Control-clock tick |
| conv_start | output | 1 | One-cycle start of a requested conversion |
| conv_chan | output | 6 | Input code of the started conversion |
| glob_pulse | output | N_TRIG | One-cycle global software trigger per input |
| glob_lvl | output | N_TRIG | Global level software trigger per input |
| hw_trig_out | output | N_TRIG | Hardware triggers after the suspend gate |
| samp_cmd | output | 1 | Sample (1) or hold (0) command |
| adc_en | output | 1 | Converter digital enable |
| upd_irq | output | 1 | Update-ready interrupt pulse |

## Verification
The request machine can get stuck in ARMED or HOLD. At the ports this appears as bit 6 reading 1 beyond two control ticks after the write. A spurious or doubled FIRE shows as an unexpected `conv_start`, which the scoreboard flags in the cycle it occurs. A wrong divider count shows in the first measured tick interval, and a pulse bit that never clears shows at the next read. A broken suspend gate is exposed by a `conv_start` or `glob_pulse` during a suspended window, or by a nonzero `hw_trig_out` there. Each of these is detected within a few cycles.

// File: rtl/adc_swtrig_pkg.sv
package adc_swtrig_pkg;

    localparam int REG_W    = 32;
    localparam int CHAN_W   = 6;
    localparam int DIV_W    = 6;
    localparam int N_SRC    = 4;
    localparam int SRC_W    = $clog2(N_SRC);
    localparam int N_EXT_IN = 8;
    localparam int N_INT_IN = 4;
    localparam int N_VALID  = N_EXT_IN + N_INT_IN;

    // bit positions of the control word
    localparam int B_CHAN   = 0;
    localparam int B_REQ    = B_CHAN + CHAN_W;
    localparam int B_PULSE  = B_REQ + 1;
    localparam int B_LEVEL  = B_PULSE + 1;
    localparam int B_SAMP   = B_LEVEL + 1;
    localparam int B_SUSP   = B_SAMP + 1;
    localparam int B_UIEN   = B_SUSP + 1;
    localparam int B_URDY   = B_UIEN + 1;
    localparam int B_EN     = B_URDY + 1;
    localparam int B_SRC    = B_EN + 1;
    localparam int B_DIV    = B_SRC + SRC_W;
    localparam int USED_W   = B_DIV + DIV_W;

    typedef enum logic [2:0] {
        REQ_IDLE,
        REQ_ARMED,
        REQ_FIRE,
        REQ_DROP,
        REQ_HOLD
    } req_state_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SRC_W-1:0]  src;
        logic              en;
        logic              uien;
        logic              susp;
        logic              samp;
        logic              level;
        logic [CHAN_W-1:0] chan;
    } ctl_fields_t;

endpackage

// File: rtl/adc_ctl_clkdiv.sv
module adc_ctl_clkdiv
    import adc_swtrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_en,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             src_hit;

    assign src_hit = src_en[src_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (src_hit) begin
                if (cnt >= div) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adc_swtrig_regs.sv
module adc_swtrig_regs
    import adc_swtrig_pkg::*;
#(
    parameter int N_TRIG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              tick,
    input  logic              req_busy,
    input  logic              upd_set,
    input  logic              upd_clr,
    input  logic [N_TRIG-1:0] sel_pulse,
    output ctl_fields_t       fields,
    output logic              req_set,
    output logic              upd_rdy,
    output logic              upd_irq,
    output logic [N_TRIG-1:0] glob_pulse,
    output logic [REG_W-1:0]  rd_data
);

    logic pulse_bit;

    assign req_set = wr_en && wr_data[B_REQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields     <= '0;
            pulse_bit  <= 1'b0;
            glob_pulse <= '0;
            upd_rdy    <= 1'b0;
            upd_irq    <= 1'b0;
        end else begin
            if (wr_en) begin
                fields.chan  <= wr_data[B_CHAN +: CHAN_W];
                fields.level <= wr_data[B_LEVEL];
                fields.samp  <= wr_data[B_SAMP];
                fields.susp  <= wr_data[B_SUSP];
                fields.uien  <= wr_data[B_UIEN];
                fields.en    <= wr_data[B_EN];
                fields.src   <= wr_data[B_SRC +: SRC_W];
                fields.div   <= wr_data[B_DIV +: DIV_W];
            end
            if (wr_en && wr_data[B_PULSE]) begin
                pulse_bit <= 1'b1;
            end else if (tick) begin
                pulse_bit <= 1'b0;
            end
            glob_pulse <= (tick && pulse_bit && !fields.susp) ? sel_pulse : '0;
            if (upd_set) begin
                upd_rdy <= 1'b1;
            end else if (upd_clr) begin
                upd_rdy <= 1'b0;
            end
            upd_irq <= upd_set && !upd_rdy && fields.uien;
        end
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[B_CHAN +: CHAN_W]    = fields.chan;
        rd_data[B_REQ]               = req_busy;
        rd_data[B_PULSE]             = pulse_bit;
        rd_data[B_LEVEL]             = fields.level;
        rd_data[B_SAMP]              = fields.samp;
        rd_data[B_SUSP]              = fields.susp;
        rd_data[B_UIEN]              = fields.uien;
        rd_data[B_URDY]              = upd_rdy;
        rd_data[B_EN]                = fields.en;
        rd_data[B_SRC +: SRC_W]      = fields.src;
        rd_data[B_DIV +: DIV_W]      = fields.div;
    end

endmodule

// File: rtl/adc_conv_req_fsm.sv
module adc_conv_req_fsm
    import adc_swtrig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_set,
    input  logic              susp,
    input  logic [CHAN_W-1:0] chan,
    output logic              busy,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan
);

    req_state_e state, state_nx;
    logic       chan_ok;

    assign chan_ok = (chan < CHAN_W'(N_VALID));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= REQ_IDLE;
            conv_chan <= '0;
        end else begin
            state <= state_nx;
            if (state == REQ_ARMED && state_nx == REQ_FIRE) begin
                conv_chan <= chan;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            REQ_IDLE:  if (req_set) state_nx = REQ_ARMED;
            REQ_ARMED: if (tick && !susp) state_nx = chan_ok ? REQ_FIRE : REQ_DROP;
            REQ_FIRE:  state_nx = REQ_HOLD;
            REQ_DROP:  state_nx = REQ_HOLD;
            REQ_HOLD:  if (tick) state_nx = REQ_IDLE;
            default:   state_nx = REQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state != REQ_IDLE);
        conv_start = (state == REQ_FIRE);
    end

endmodule

// File: rtl/adc_swtrig_ctrl.sv
module adc_swtrig_ctrl
    import adc_swtrig_pkg::*;
#(
    parameter int N_TRIG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_en,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [N_TRIG-1:0] sel_pulse,
    input  logic [N_TRIG-1:0] sel_lvl,
    input  logic [N_TRIG-1:0] hw_trig_in,
    input  logic              auto_samp,
    input  logic              upd_set,
    input  logic              upd_clr,
    output logic              ctl_tick,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [N_TRIG-1:0] glob_pulse,
    output logic [N_TRIG-1:0] glob_lvl,
    output logic [N_TRIG-1:0] hw_trig_out,
    output logic              samp_cmd,
    output logic              adc_en,
    output logic              upd_irq
);

    ctl_fields_t fields;
    logic        req_set;
    logic        req_busy;
    logic        upd_rdy;

    adc_ctl_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  (src_en),
        .src_sel (fields.src),
        .div     (fields.div),
        .tick    (ctl_tick)
    );

    adc_swtrig_regs #(.N_TRIG(N_TRIG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tick       (ctl_tick),
        .req_busy   (req_busy),
        .upd_set    (upd_set),
        .upd_clr    (upd_clr),
        .sel_pulse  (sel_pulse),
        .fields     (fields),
        .req_set    (req_set),
        .upd_rdy    (upd_rdy),
        .upd_irq    (upd_irq),
        .glob_pulse (glob_pulse),
        .rd_data    (rd_data)
    );

    adc_conv_req_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (ctl_tick),
        .req_set    (req_set),
        .susp       (fields.susp),
        .chan       (fields.chan),
        .busy       (req_busy),
        .conv_start (conv_start),
        .conv_chan  (conv_chan)
    );

    assign glob_lvl    = (fields.level && !fields.susp) ? sel_lvl : '0;
    assign hw_trig_out = fields.susp ? '0 : hw_trig_in;
    assign samp_cmd    = fields.samp ? 1'b1 : auto_samp;
    assign adc_en      = fields.en;

endmodule

// File: rtl/adc_swtrig_ctrl_chk.sv
module adc_swtrig_ctrl_chk
    import adc_swtrig_pkg::*;
#(
    parameter int N_TRIG = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  rd_data,
    input logic              ctl_tick,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic [N_TRIG-1:0] glob_pulse,
    input logic [N_TRIG-1:0] glob_lvl,
    input logic [N_TRIG-1:0] hw_trig_out,
    input logic              samp_cmd,
    input logic              upd_irq
);

    assert_start_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(ctl_tick));

    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_start_valid_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan < CHAN_W'(N_VALID)));

    assert_start_unsuspended_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(rd_data[B_SUSP]));

    assert_suspend_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_SUSP] |-> (hw_trig_out == '0 && glob_lvl == '0));

    assert_pulse_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_pulse != '0) |-> ($past(ctl_tick) && !$past(rd_data[B_SUSP])));

    assert_manual_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_SAMP] |-> samp_cmd);

    assert_irq_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> (rd_data[B_URDY] && !$past(rd_data[B_URDY]) && $past(rd_data[B_UIEN])));

endmodule

bind adc_swtrig_ctrl adc_swtrig_ctrl_chk #(.N_TRIG(N_TRIG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data     (rd_data),
    .ctl_tick    (ctl_tick),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .glob_pulse  (glob_pulse),
    .glob_lvl    (glob_lvl),
    .hw_trig_out (hw_trig_out),
    .samp_cmd    (samp_cmd),
    .upd_irq     (upd_irq)
);

// File: tb/adc_swtrig_ctrl_bench.sv
module adc_swtrig_ctrl_bench;

    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    src_en;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NT-1:0] sel_pulse = '0, sel_lvl = '0, hw_trig_in = '0;
    logic          auto_samp = 1'b0, upd_set = 1'b0, upd_clr = 1'b0;
    logic          ctl_tick, conv_start, samp_cmd, adc_en, upd_irq;
    logic [5:0]    conv_chan;
    logic [NT-1:0] glob_pulse, glob_lvl, hw_trig_out;
    logic          ph = 1'b0;

    int checks = 0;
    int errors = 0;
    int n_starts = 0;
    logic [5:0] exp_q[$];

    always #10ns clk = ~clk;
    always @(negedge clk) ph <= ~ph;
    assign src_en = {1'b1, 1'b0, ph, 1'b1};

    adc_swtrig_ctrl #(.N_TRIG(NT)) u_adc_swtrig_ctrl (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sel_pulse(sel_pulse), .sel_lvl(sel_lvl),
        .hw_trig_in(hw_trig_in), .auto_samp(auto_samp), .upd_set(upd_set),
        .upd_clr(upd_clr), .ctl_tick(ctl_tick), .conv_start(conv_start),
        .conv_chan(conv_chan), .glob_pulse(glob_pulse), .glob_lvl(glob_lvl),
        .hw_trig_out(hw_trig_out), .samp_cmd(samp_cmd), .adc_en(adc_en),
        .upd_irq(upd_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // control word per R2
    function automatic logic [31:0] mkw(input logic [5:0] chan, input bit req, input bit pls,
        input bit lvl, input bit samp, input bit susp, input bit uien, input bit en,
        input logic [1:0] src, input logic [5:0] div);
        mkw = {10'b0, div, src, en, 1'b0, uien, susp, samp, lvl, pls, req, chan};
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period(output int p);
        int w = 0;
        while (!ctl_tick && w < 300) begin @(negedge clk); w++; end
        p = 0;
        do begin @(negedge clk); p++; end while (!ctl_tick && p < 300);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            n_starts++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected start", 32'(conv_chan), 32'hFFFF);
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                check(conv_chan == e, "R6 start channel", 32'(conv_chan), 32'(e));
            end
        end
    end

    initial begin
        #(20ns * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p;
        int s0;
        step(3);
        // R1 reset state
        check(rd_data == 0, "R1 word", rd_data, 0);
        check({conv_start, glob_pulse, glob_lvl, hw_trig_out, upd_irq, samp_cmd, adc_en} == 0,
              "R1 outputs", 0, 0);
        rst_n = 1'b1;
        step(2);

        // R2 readback, reserved bits, status not writable
        wr(32'hFFC0_0000 | mkw(6'h2A, 0, 0, 1, 0, 0, 1, 1, 2'd2, 6'h15) | 32'h1000);
        check(rd_data == mkw(6'h2A, 0, 0, 1, 0, 0, 1, 1, 2'd2, 6'h15), "R2 readback",
              rd_data, mkw(6'h2A, 0, 0, 1, 0, 0, 1, 1, 2'd2, 6'h15));

        // R3 divider
        wr(mkw(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 6'd3));
        period(p); period(p);
        check(p == 4, "R3 src0 div3", p, 4);
        wr(mkw(0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 6'd2));
        period(p); period(p);
        check(p == 6, "R3 src1 div2", p, 6);
        wr(mkw(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 6'd0));
        step(2);
        check(ctl_tick == 1'b1, "R3 div0 every cycle", ctl_tick, 1);

        // R5 level
        sel_lvl = 8'h3C;
        wr(mkw(0, 0, 0, 1, 0, 0, 0, 1, 2'd0, 0));
        check(glob_lvl == 8'h3C, "R5 level on", glob_lvl, 8'h3C);
        wr(mkw(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 0));
        check(glob_lvl == 0, "R5 level off", glob_lvl, 0);

        // R4 global pulse
        sel_pulse = 8'hA5;
        wr(mkw(0, 0, 1, 0, 0, 0, 0, 1, 2'd0, 0));
        step(1);
        check(glob_pulse == 8'hA5, "R4 pulse", glob_pulse, 8'hA5);
        check(rd_data[7] == 1'b0, "R4 bit cleared", rd_data[7], 0);
        step(1);
        check(glob_pulse == 0, "R4 single", glob_pulse, 0);

        // R6 request, cycle exact
        exp_q.push_back(6'd5);
        wr(mkw(6'd5, 1, 0, 0, 0, 0, 0, 1, 2'd0, 0));
        check(rd_data[6] == 1'b1, "R6 bit set", rd_data[6], 1);
        step(1);
        check(conv_start == 1'b1, "R6 pulse timing", conv_start, 1);
        check(rd_data[6] == 1'b1, "R6 bit held at pulse", rd_data[6], 1);
        step(2);
        check(rd_data[6] == 1'b0, "R6 bit cleared", rd_data[6], 0);
        exp_q.push_back(6'd11);
        wr(mkw(6'd11, 1, 0, 0, 0, 0, 0, 1, 2'd0, 0));
        step(4);
        check(exp_q.size() == 0, "R6 code 11 started", exp_q.size(), 0);

        // R7 reserved code dropped
        s0 = n_starts;
        wr(mkw(6'd12, 1, 0, 0, 0, 0, 0, 1, 2'd0, 0));
        step(3);
        check(rd_data[6] == 1'b0, "R7 bit cleared", rd_data[6], 0);
        check(n_starts == s0, "R7 no start", n_starts, s0);

        // R8 suspend
        hw_trig_in = 8'h0F;
        sel_lvl = 8'hFF;
        s0 = n_starts;
        wr(mkw(6'd3, 1, 1, 1, 0, 1, 0, 1, 2'd0, 0));
        step(10);
        check(n_starts == s0, "R8 no start", n_starts, s0);
        check(rd_data[6] == 1'b1, "R8 request pending", rd_data[6], 1);
        check(rd_data[7] == 1'b0, "R8 pulse bit lost", rd_data[7], 0);
        check(glob_lvl == 0 && hw_trig_out == 0 && glob_pulse == 0, "R8 gated",
              {glob_lvl, hw_trig_out}, 0);
        check(adc_en == 1'b1, "R8 enable kept", adc_en, 1);
        exp_q.push_back(6'd3);
        wr(mkw(6'd3, 0, 0, 0, 0, 0, 0, 1, 2'd0, 0));
        step(4);
        check(exp_q.size() == 0 && rd_data[6] == 0, "R8 pending fires", exp_q.size(), 0);

        // R11 hardware pass
        check(hw_trig_out == 8'h0F, "R11 pass", hw_trig_out, 8'h0F);

        // R9 manual sample
        auto_samp = 1'b0;
        wr(mkw(0, 0, 0, 0, 1, 0, 0, 1, 2'd0, 0));
        check(samp_cmd == 1'b1, "R9 manual wins", samp_cmd, 1);
        wr(mkw(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 0));
        check(samp_cmd == 1'b0, "R9 auto low", samp_cmd, 0);
        auto_samp = 1'b1;
        step(1);
        check(samp_cmd == 1'b1, "R9 auto high", samp_cmd, 1);

        // R10 update ready
        wr(mkw(0, 0, 0, 0, 0, 0, 1, 1, 2'd0, 0));
        upd_set = 1'b1;
        step(1);
        upd_set = 1'b0;
        check(upd_irq == 1'b1 && rd_data[12] == 1'b1, "R10 irq", {upd_irq, rd_data[12]}, 3);
        step(1);
        check(upd_irq == 1'b0, "R10 irq single", upd_irq, 0);
        upd_clr = 1'b1;
        step(1);
        upd_clr = 1'b0;
        check(rd_data[12] == 1'b0, "R10 clear", rd_data[12], 0);
        wr(mkw(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 0));
        upd_set = 1'b1;
        step(1);
        upd_set = 1'b0;
        check(upd_irq == 1'b0 && rd_data[12] == 1'b1, "R10 masked", {upd_irq, rd_data[12]}, 1);

        step(3);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule